// File: doc/BRIEF.md
# Dual-Channel Center-Aligned PWM Timer

This block is an 8-bit timer that counts up and down between zero and a programmable upper limit. It drives two compare channels, A and B, and each channel produces a center-aligned, symmetric pulse-width-modulated wave. The counter moves one step only on cycles where the external clock-enable strobe `tick` is high. The strobe comes from a shared prescaler that divides the I/O clock by 1, 8, 64, 256 or 1024. One full period takes 2 × TOP steps, so the PWM frequency is the I/O clock divided by 2 × N × TOP.

Each channel has its own compare value and its own 2-bit output mode. The mode selects one of four behaviours: disconnected (held low), toggle on match (channel A only), non-inverted PWM or inverted PWM. Compare values written by software go into a holding register. They become active only when the counter arrives at TOP, so a period is never cut short. When the counter reaches TOP, the PWM level is forced to the value an up-count match would produce. This keeps the wave symmetric when a match was skipped or when the compare value has moved away from TOP. A sticky flag marks each return to zero.

Top module: `pwm_center_timer`

## Requirements
- R1: With `top_lim` ≥ 2 and `tick` high every cycle, `cnt` follows 0,1,…,TOP,TOP−1,…,0,1,… and takes exactly 2·TOP steps per period. It never advances on a cycle where `tick` is low.
- R2: `ovf_flag` is set on the step that brings `cnt` to 0, and it then stays set. A cycle with `flag_clr` = 1 clears it, unless that same cycle sets it again; the set wins.
- R3: Mode 2'b10 is non-inverted PWM. A match on an up step drives the wave low, and a match on a down step drives it high. With 0 < C < TOP, the wave is high for 2·C of the 2·TOP steps in each period.
- R4: Mode 2'b11 is inverted PWM. A match on an up step drives the wave high, and a match on a down step drives it low. With 0 < C < TOP, the wave is high for 2·TOP − 2·C steps per period.
- R5: Mode 2'b01 with `toggle_a_en` = 1 inverts `wave_a` on every match, whether the counter is moving up or down. On channel B, or with `toggle_a_en` = 0, mode 2'b01 drives the wave to 0. Mode 2'b00 drives the wave to 0 on the next step.
- R6: In the PWM modes, an active compare value of 0 holds the wave at its inactive level on every step (low in 2'b10, high in 2'b11). A value ≥ TOP holds it at its active level for the whole period.
- R7: In the PWM modes, the step that reaches TOP sets the wave to the up-match level whenever the active compare value is below TOP. This happens even if no match occurred on the way up, for example after the count was loaded above the compare value, or after the compare value was lowered from TOP.
- R8: A compare write goes to a holding register. The active value (`cmp_a_act`, `cmp_b_act`) is replaced by the holding register only on the step that reaches TOP, and the match on that same step already uses the new value. If a write lands on the reload step, the old held value is loaded and the written value is kept for the next reload.
- R9: `cnt_wr` loads `cnt_wdata` into the counter on the next edge and takes priority over `tick`. The load keeps the count direction and causes no compare action, no flag set and no reload.
- R10: While `tick` is low, `cnt`, `wave_a` and `wave_b` keep their values, even if the mode inputs change.
- R11: After reset, `cnt` = 0, the direction is up, both waves are 0, `ovf_flag` = 0, and both the active and the held compare values are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable |
| top_lim | input | 8 | Upper turning point TOP (≥ 2) |
| cnt_wr | input | 1 | Load the counter |
| cnt_wdata | input | 8 | Counter load value |
| cmp_a_wr | input | 1 | Write channel A holding compare |
| cmp_a_wdata | input | 8 | Channel A compare write data |
| cmp_b_wr | input | 1 | Write channel B holding compare |
| cmp_b_wdata | input | 8 | Channel B compare write data |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| toggle_a_en | input | 1 | Enables toggle behaviour of mode 2'b01 on channel A |
| flag_clr | input | 1 | Write-one clear of the overflow flag |
| cnt | output | 8 | Current count |
| cmp_a_act | output | 8 | Active compare value, channel A |
| cmp_b_act | output | 8 | Active compare value, channel B |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Sticky bottom-reached flag |

## Verification
The overflow flag can be set by the counter and cleared by software in the same cycle. The bench provokes this by asserting `flag_clr` on exactly the tick that moves the count from 1 to 0. The flag must read 1 on the following cycle, and a later clear-only cycle must bring it to 0. A counter load can likewise coincide with a tick. The bench drives both together and expects the loaded value rather than an increment, and then expects the count to continue in the original direction.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int CNT_W  = 8;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_PWM    = 2'b10,
        OM_PWM_N  = 2'b11
    } out_mode_e;

endpackage

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
    parameter int W = pwm_tmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top_lim,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_cur,
    output logic [W-1:0] cnt_nxt,
    output logic         step_up,
    output logic         adv,
    output logic         at_top,
    output logic         ovf
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir_up;
        logic         ovf;
    } ctr_t;

    ctr_t s_d, s_q;
    logic         up_w;
    logic [W-1:0] nxt_w;

    always_comb begin
        // pick step direction; a count above TOP while going up turns around
        up_w  = s_q.dir_up ? (s_q.cnt < top_lim) : (s_q.cnt == '0);
        nxt_w = up_w ? s_q.cnt + 1'b1 : s_q.cnt - 1'b1;

        s_d = s_q;
        if (flag_clr) begin
            s_d.ovf = 1'b0;
        end
        if (cnt_wr) begin
            s_d.cnt = cnt_wdata;
        end else if (tick) begin
            s_d.cnt    = nxt_w;
            s_d.dir_up = up_w ? (nxt_w != top_lim) : (nxt_w == '0);
            if (nxt_w == '0) begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, dir_up: 1'b1, ovf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_cur = s_q.cnt;
    assign cnt_nxt = nxt_w;
    assign step_up = up_w;
    assign adv     = tick & ~cnt_wr;
    assign at_top  = adv & (nxt_w == top_lim);
    assign ovf     = s_q.ovf;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(s_q.cnt)); // R10
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (s_q.cnt == $past(cnt_wdata))); // R9
    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !flag_clr) |=> s_q.ovf); // R2
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !s_q.dir_up && s_q.cnt == {{(W-1){1'b0}}, 1'b1}) |=> s_q.ovf); // R2

endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel #(
    parameter int W         = pwm_tmr_pkg::CNT_W,
    parameter bit TOGGLE_OK = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         at_top,
    input  logic         step_up,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] top_lim,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic [1:0]   mode,
    input  logic         toggle_en,
    output logic [W-1:0] cmp_act,
    output logic         wave
);
    import pwm_tmr_pkg::*;

    typedef struct packed {
        logic [W-1:0] cmp_buf;
        logic [W-1:0] cmp_act;
        logic         wave;
    } ch_t;

    ch_t s_d, s_q;
    logic [W-1:0] cmp_eff;
    logic         hit;
    logic         lvl_up;
    logic         lvl_dn;
    out_mode_e    md;

    always_comb begin
        md      = out_mode_e'(mode);
        cmp_eff = at_top ? s_q.cmp_buf : s_q.cmp_act;
        hit     = (cnt_nxt == cmp_eff);
        lvl_up  = (md == OM_PWM_N);
        lvl_dn  = ~lvl_up;

        s_d = s_q;
        if (cmp_wr) begin
            s_d.cmp_buf = cmp_wdata;
        end
        if (at_top) begin
            s_d.cmp_act = s_q.cmp_buf;
        end

        if (adv) begin
            unique case (md)
                OM_PWM, OM_PWM_N: begin
                    if (at_top) begin
                        s_d.wave = (cmp_eff >= top_lim) ? lvl_dn : lvl_up;
                    end else if (cmp_eff == '0) begin
                        s_d.wave = lvl_up;
                    end else if (hit) begin
                        s_d.wave = step_up ? lvl_up : lvl_dn;
                    end
                end
                OM_TOGGLE: begin
                    if (TOGGLE_OK && toggle_en) begin
                        if (hit) begin
                            s_d.wave = ~s_q.wave;
                        end
                    end else begin
                        s_d.wave = 1'b0;
                    end
                end
                default: s_d.wave = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_act = s_q.cmp_act;
    assign wave    = s_q.wave;

    AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(s_q.wave)); // R10
    AST_CMP_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_top |=> $stable(s_q.cmp_act)); // R8
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode == 2'b00) |=> !s_q.wave); // R5
    AST_TOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && mode == 2'b10 && s_q.cmp_buf < top_lim) |=> !s_q.wave); // R7

endmodule

// File: rtl/pwm_center_timer.sv
module pwm_center_timer #(
    parameter int W = pwm_tmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top_lim,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_a_wr,
    input  logic [W-1:0] cmp_a_wdata,
    input  logic         cmp_b_wr,
    input  logic [W-1:0] cmp_b_wdata,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic         toggle_a_en,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_a_act,
    output logic [W-1:0] cmp_b_act,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovf_flag
);
    import pwm_tmr_pkg::*;

    localparam int NCH = NUM_CH;

    logic [W-1:0] cnt_nxt;
    logic         step_up;
    logic         adv;
    logic         at_top;

    logic [NCH-1:0]        ch_wr;
    logic [NCH-1:0][W-1:0] ch_wdata;
    logic [NCH-1:0][1:0]   ch_mode;
    logic [NCH-1:0][W-1:0] ch_act;
    logic [NCH-1:0]        ch_wave;

    assign ch_wr    = {cmp_b_wr, cmp_a_wr};
    assign ch_wdata = {cmp_b_wdata, cmp_a_wdata};
    assign ch_mode  = {mode_b, mode_a};

    pwm_tmr_counter #(.W(W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .top_lim   (top_lim),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .flag_clr  (flag_clr),
        .cnt_cur   (cnt),
        .cnt_nxt   (cnt_nxt),
        .step_up   (step_up),
        .adv       (adv),
        .at_top    (at_top),
        .ovf       (ovf_flag)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_tmr_channel #(
            .W         (W),
            .TOGGLE_OK (i == 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv       (adv),
            .at_top    (at_top),
            .step_up   (step_up),
            .cnt_nxt   (cnt_nxt),
            .top_lim   (top_lim),
            .cmp_wr    (ch_wr[i]),
            .cmp_wdata (ch_wdata[i]),
            .mode      (ch_mode[i]),
            .toggle_en (toggle_a_en),
            .cmp_act   (ch_act[i]),
            .wave      (ch_wave[i])
        );
    end

    assign cmp_a_act = ch_act[0];
    assign cmp_b_act = ch_act[1];
    assign wave_a    = ch_wave[0];
    assign wave_b    = ch_wave[1];

    AST_B_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && mode_b == 2'b01) |=> !wave_b); // R5

endmodule

// File: tb/tb_pwm_center_timer.sv
`timescale 1ns/1ps
module tb_pwm_center_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] top_lim = 8'd10;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       cmp_a_wr = 1'b0;
    logic [7:0] cmp_a_wdata = '0;
    logic       cmp_b_wr = 1'b0;
    logic [7:0] cmp_b_wdata = '0;
    logic [1:0] mode_a = '0;
    logic [1:0] mode_b = '0;
    logic       toggle_a_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] cnt, cmp_a_act, cmp_b_act;
    logic       wave_a, wave_b, ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwm_center_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_lim(top_lim),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_a_wr(cmp_a_wr), .cmp_a_wdata(cmp_a_wdata),
        .cmp_b_wr(cmp_b_wr), .cmp_b_wdata(cmp_b_wdata),
        .mode_a(mode_a), .mode_b(mode_b), .toggle_a_en(toggle_a_en),
        .flag_clr(flag_clr), .cnt(cnt), .cmp_a_act(cmp_a_act),
        .cmp_b_act(cmp_b_act), .wave_a(wave_a), .wave_b(wave_b),
        .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [7:0]  top;
        logic [7:0]  ca;
        logic [1:0]  ma;
        logic [7:0]  cb;
        logic [1:0]  mb;
        logic [15:0] ha;
        logic [15:0] hb;
    } vec_t;

    // expected high counts per period: mode 2 -> 2C, mode 3 -> 2TOP-2C, clamps per R6
    localparam vec_t VECS [8] = '{
        '{8'd10,  8'd4,   2'b10, 8'd4,   2'b11, 16'd8,   16'd12},
        '{8'd10,  8'd0,   2'b10, 8'd0,   2'b11, 16'd0,   16'd20},
        '{8'd10,  8'd10,  2'b10, 8'd10,  2'b11, 16'd20,  16'd0},
        '{8'd10,  8'd200, 2'b10, 8'd1,   2'b10, 16'd20,  16'd2},
        '{8'd10,  8'd9,   2'b11, 8'd3,   2'b00, 16'd2,   16'd0},
        '{8'd50,  8'd25,  2'b10, 8'd25,  2'b01, 16'd50,  16'd0},
        '{8'd3,   8'd1,   2'b10, 8'd2,   2'b11, 16'd2,   16'd2},
        '{8'd200, 8'd100, 2'b11, 8'd199, 2'b10, 16'd200, 16'd398}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        cyc(n);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; cnt_wr = 1'b0; cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
        flag_clr = 1'b0; mode_a = '0; mode_b = '0; toggle_a_en = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic wr_cmp(input logic [7:0] a, input logic [7:0] b);
        cmp_a_wr = 1'b1; cmp_a_wdata = a;
        cmp_b_wr = 1'b1; cmp_b_wdata = b;
        cyc(1);
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R11 reset state
        chk(cnt == 0 && wave_a == 0 && wave_b == 0, "R11", "cnt/waves after reset",
            {cnt, wave_a, wave_b}, 0);
        chk(ovf_flag == 0 && cmp_a_act == 0 && cmp_b_act == 0, "R11", "flag/cmp after reset",
            {ovf_flag, cmp_a_act, cmp_b_act}, 0);

        // table walk: R1 triangle, R3/R4/R5/R6 duty, R8 reload, R2 flag
        foreach (VECS[e]) begin
            int ha, hb, cbad;
            do_reset();
            top_lim = VECS[e].top;
            mode_a = VECS[e].ma; mode_b = VECS[e].mb; toggle_a_en = 1'b1;
            wr_cmp(VECS[e].ca, VECS[e].cb);
            chk(cmp_a_act == 0, "R8", "active cmp before TOP", cmp_a_act, 0);
            ticks(int'(VECS[e].top));
            chk(cnt == VECS[e].top && cmp_a_act == VECS[e].ca && cmp_b_act == VECS[e].cb,
                "R8", "reload at TOP", cmp_a_act, VECS[e].ca);
            ha = 0; hb = 0; cbad = 0;
            tick = 1'b1;
            for (int k = 1; k <= 2 * int'(VECS[e].top); k++) begin
                int ev;
                cyc(1);
                ev = (k <= int'(VECS[e].top)) ? int'(VECS[e].top) - k : k - int'(VECS[e].top);
                if (int'(cnt) != ev) cbad++;
                ha += wave_a; hb += wave_b;
            end
            tick = 1'b0;
            chk(cbad == 0, "R1", "triangle count sequence mismatches", cbad, 0);
            chk(ha == int'(VECS[e].ha), "R3", "channel A high steps (R4 R6)", ha, VECS[e].ha);
            chk(hb == int'(VECS[e].hb), "R4", "channel B high steps (R3 R5 R6)", hb, VECS[e].hb);
            chk(ovf_flag == 1'b1, "R2", "flag after bottom", ovf_flag, 1);
        end

        // R10 hold with tick low, R1 advance only on tick
        do_reset(); top_lim = 8'd10;
        ticks(3);
        chk(cnt == 3, "R1", "count after 3 ticks", cnt, 3);
        cyc(5);
        chk(cnt == 3, "R10", "count with tick low", cnt, 3);

        // R9 load beats tick, direction kept
        cnt_wr = 1'b1; cnt_wdata = 8'd7; tick = 1'b1;
        cyc(1);
        cnt_wr = 1'b0; tick = 1'b0;
        chk(cnt == 7, "R9", "load wins over tick", cnt, 7);
        ticks(1);
        chk(cnt == 8, "R9", "direction kept after load", cnt, 8);

        // R2 flag set, sticky, clear, set-wins
        do_reset(); top_lim = 8'd4;
        ticks(7);
        chk(ovf_flag == 0, "R2", "flag before bottom", ovf_flag, 0);
        ticks(1);
        chk(ovf_flag == 1, "R2", "flag at bottom", ovf_flag, 1);
        cyc(3);
        chk(ovf_flag == 1, "R2", "flag sticky", ovf_flag, 1);
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk(ovf_flag == 0, "R2", "flag cleared", ovf_flag, 0);
        ticks(7);
        tick = 1'b1; flag_clr = 1'b1; cyc(1); tick = 1'b0; flag_clr = 1'b0;
        chk(cnt == 0 && ovf_flag == 1, "R2", "set wins over clear", ovf_flag, 1);
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk(ovf_flag == 0, "R2", "clear after collision", ovf_flag, 0);

        // R8 + R7: compare lowered from TOP
        do_reset(); top_lim = 8'd10; mode_a = 2'b10;
        wr_cmp(8'd10, 8'd0);
        ticks(10);
        chk(wave_a == 1, "R6", "cmp at TOP gives high", wave_a, 1);
        ticks(3);
        wr_cmp(8'd4, 8'd0);
        chk(cmp_a_act == 10, "R8", "active cmp kept mid-period", cmp_a_act, 10);
        ticks(16);
        chk(cnt == 9 && wave_a == 1, "R8", "old compare still in use", wave_a, 1);
        ticks(1);
        chk(cmp_a_act == 4 && wave_a == 0, "R7", "forced low at TOP after lowering", wave_a, 0);

        // R7: count loaded above compare skips the up match
        do_reset(); top_lim = 8'd10; mode_a = 2'b10;
        wr_cmp(8'd4, 8'd0);
        ticks(10);
        chk(wave_a == 0, "R7", "low at TOP", wave_a, 0);
        ticks(11);
        chk(cnt == 1 && wave_a == 1, "R3", "high after down match", wave_a, 1);
        cnt_wr = 1'b1; cnt_wdata = 8'd7; cyc(1); cnt_wr = 1'b0;
        ticks(2);
        chk(cnt == 9 && wave_a == 1, "R7", "no match on skipped path", wave_a, 1);
        ticks(1);
        chk(cnt == 10 && wave_a == 0, "R7", "forced low at TOP after skip", wave_a, 0);

        // R5 toggle on channel A, R10 hold, mode off
        do_reset(); top_lim = 8'd10; mode_a = 2'b01; toggle_a_en = 1'b1;
        wr_cmp(8'd4, 8'd0);
        ticks(10);
        chk(wave_a == 0, "R5", "toggle idle before match", wave_a, 0);
        ticks(6);
        chk(cnt == 4 && wave_a == 1, "R5", "toggle on down match", wave_a, 1);
        ticks(8);
        chk(cnt == 4 && wave_a == 0, "R5", "toggle on up match", wave_a, 0);
        ticks(12);
        chk(cnt == 4 && wave_a == 1, "R5", "toggle again", wave_a, 1);
        mode_a = 2'b00;
        cyc(3);
        chk(wave_a == 1, "R10", "wave held with tick low", wave_a, 1);
        ticks(1);
        chk(wave_a == 0, "R5", "mode off drives low", wave_a, 0);

        // R11 reset mid-run
        ticks(5);
        rst_n = 1'b0; cyc(1);
        chk(cnt == 0 && ovf_flag == 0 && cmp_a_act == 0, "R11", "state after mid-run reset",
            cnt, 0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule